// File: doc/BRIEF.md
# Integer Condition-Code Unit with Branch Evaluator

This block is the integer arithmetic and branch-decision slice of a simple in-order core. Each cycle it adds or subtracts two 32-bit operands and drives the sum or difference on `result` combinationally. The second operand is either a register value or a 13-bit signed immediate, which the block sign-extends itself.

A four-bit condition-code register holds negative, zero, overflow and carry. It is loaded at the clock edge only when the instruction is valid and is a flag-setting variant. A branch-condition select is evaluated against the registered flags, so a branch issued in the cycle after a flag-setting instruction sees that instruction's flags.

The unit accepts an operation every cycle and applies no back-pressure. `op_valid` only qualifies the flag update, since the arithmetic path is purely combinational.

Top module: `icc_branch_unit`

## Requirements
- R1: At a rising edge where `op_valid` and `set_cc` are both 1, Z is loaded with (result == 0) and N with result bit 31. Both are visible on `flags` in the following cycle.
- R2: On a flag-setting add, C is loaded with the carry out of bit 31. On a flag-setting subtract, C is loaded with the borrow, which is 1 when `opnd_a` is unsigned-less than the second operand.
- R3: V is set on add when both operands have the same sign and the result sign differs. V is set on subtract when the operand signs differ and the result sign differs from `opnd_a`.
- R4: When `set_cc` is 0 or `op_valid` is 0, the flags keep their value, while `result` still shows the add (`op_sub`=0) or subtract (`op_sub`=1).
- R5: With `b_is_imm`=1 the second operand is `imm13` sign-extended to 32 bits (range -4096 to 4095), and `opnd_b` is ignored.
- R6: `cond_sel`=3'b100 (always) gives `taken`=1 and `cond_sel`=3'b000 (never) gives `taken`=0, whatever the flags.
- R7: The base conditions are evaluated from the registered flags: 3'b001 equal is Z, 3'b011 less is N^V, and 3'b010 less-or-equal is Z|(N^V).
- R8: Setting `cond_sel` bit 2 gives the exact inverse of the same base: 3'b101 not-equal, 3'b111 greater-or-equal and 3'b110 greater.
- R9: While `rst_n` is 0 the flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An instruction is present this cycle |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| set_cc | input | 1 | Instruction updates the condition codes |
| b_is_imm | input | 1 | Select the sign-extended immediate as second operand |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Register second operand |
| imm13 | input | 13 | Signed immediate second operand |
| cond_sel | input | 3 | Branch condition: bit 2 inverts, bits 1:0 pick never/eq/le/lt |
| result | output | 32 | Sum or difference |
| flags | output | 4 | Registered flags {N, Z, V, C} |
| taken | output | 1 | Branch condition holds for the current flags |

## Verification
Since the flags are the only state, a wrong update appears on `flags` one cycle after the faulty instruction. It also flips `taken` for any condition that reads the damaged bit in that same cycle. A missed hold (R4) is seen as a flag change after a non-setting instruction. Wrong borrow or overflow polarity is exposed by the boundary operands 0x7FFFFFFF+1, 0x80000000-1 and 0-1. The bench compares all outputs against a behavioural model on every clock.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } icc_flags_t;

  typedef enum logic [1:0] {
    BASE_FALSE = 2'd0,
    BASE_EQ    = 2'd1,
    BASE_LE    = 2'd2,
    BASE_LT    = 2'd3
  } icc_base_e;
endpackage

// File: rtl/icc_addsub.sv
module icc_addsub
  import icc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output icc_flags_t   nxt
);
  logic [W:0]   wide;
  logic [W-1:0] b_inv;

  assign b_inv = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_inv} + {{W{1'b0}}, sub};
  assign res   = wide[W-1:0];

  always_comb begin
    nxt.n = res[W-1];
    nxt.z = (res == '0);
    nxt.c = sub ? ~wide[W] : wide[W];
    if (sub)
      nxt.v = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
    else
      nxt.v = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
  end
endmodule

// File: rtl/icc_flag_reg.sv
module icc_flag_reg
  import icc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  icc_flags_t d,
  output icc_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (load)
      q <= d;
  end
endmodule

// File: rtl/icc_cond_eval.sv
module icc_cond_eval
  import icc_pkg::*;
(
  input  icc_flags_t f,
  input  logic [2:0] cond,
  output logic       taken
);
  logic      base;
  icc_base_e sel;

  assign sel = icc_base_e'(cond[1:0]);

  always_comb begin
    unique case (sel)
      BASE_EQ: base = f.z;
      BASE_LT: base = f.n ^ f.v;
      BASE_LE: base = f.z | (f.n ^ f.v);
      default: base = 1'b0;
    endcase
  end

  assign taken = base ^ cond[2];
endmodule

// File: rtl/icc_branch_unit.sv
module icc_branch_unit
  import icc_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_sub,
  input  logic             set_cc,
  input  logic             b_is_imm,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic [IMM_W-1:0] imm13,
  input  logic [2:0]       cond_sel,
  output logic [W-1:0]     result,
  output logic [3:0]       flags,
  output logic             taken
);
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] imm_ext;
  logic [W-1:0] b_sel;
  icc_flags_t   f_nxt;
  icc_flags_t   f_q;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm13[IMM_W-1]}}, imm13};
    end else begin : g_trunc
      assign imm_ext = imm13[W-1:0];
    end
  endgenerate

  assign b_sel = b_is_imm ? imm_ext : opnd_b;

  icc_addsub #(.W(W)) u_addsub (
    .a   (opnd_a),
    .b   (b_sel),
    .sub (op_sub),
    .res (result),
    .nxt (f_nxt)
  );

  icc_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (op_valid && set_cc),
    .d     (f_nxt),
    .q     (f_q)
  );

  icc_cond_eval u_cond (
    .f     (f_q),
    .cond  (cond_sel),
    .taken (taken)
  );

  assign flags = f_q;
endmodule

// File: rtl/icc_branch_unit_chk.sv
module icc_branch_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         set_cc,
  input logic [2:0]   cond_sel,
  input logic [W-1:0] result,
  input logic [3:0]   flags,
  input logic         taken
);
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && set_cc) |=> $stable(flags)); // R4
  AST_ZN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && set_cc) |=> (flags[3] == $past(result[W-1]) &&
                              flags[2] == ($past(result) == '0))); // R1
  AST_BR_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 3'b100) |-> taken); // R6
  AST_BR_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 3'b000) |-> !taken); // R6
  AST_BR_NE: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 3'b101) |-> (taken == !flags[2])); // R8
  AST_BR_GE: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 3'b111) |-> (taken == !(flags[3] ^ flags[1]))); // R8
endmodule

bind icc_branch_unit icc_branch_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .set_cc   (set_cc),
  .cond_sel (cond_sel),
  .result   (result),
  .flags    (flags),
  .taken    (taken)
);

// File: tb/icc_branch_unit_tb_top.sv
module icc_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_sub = 1'b0, set_cc = 1'b0, b_is_imm = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [12:0] imm13 = '0;
  logic [2:0]  cond_sel = '0;
  logic [31:0] result;
  logic [3:0]  flags;
  logic        taken;

  int n_checks = 0;
  int n_fail = 0;
  logic [3:0] m_flags = 4'h0; // {N,Z,V,C}

  always #10 clk = ~clk;

  icc_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
    .set_cc(set_cc), .b_is_imm(b_is_imm), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm13(imm13), .cond_sel(cond_sel), .result(result), .flags(flags),
    .taken(taken)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string cond_tag(input logic [2:0] c);
    case (c)
      3'b000, 3'b100: return "R6 never/always";
      3'b001, 3'b010, 3'b011: return "R7 base condition";
      default: return "R8 complement";
    endcase
  endfunction

  // One instruction: drive after falling edge, check before rising edge.
  task automatic step(input logic v, input logic s, input logic cc, input logic im,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [12:0] imm, input logic [2:0] c);
    longint unsigned ua, ub, sum;
    longint sa, sb, exact;
    logic [31:0] e_res;
    logic n, z, ov, cy, lt, base, e_taken;
    @(negedge clk);
    op_valid = v; op_sub = s; set_cc = cc; b_is_imm = im;
    opnd_a = a; opnd_b = b; imm13 = imm; cond_sel = c;
    #5;
    sb = im ? longint'($signed(imm)) : longint'($signed(b));
    sa = longint'($signed(a));
    ua = longint'(a);
    ub = longint'(sb) & 64'hFFFF_FFFF;
    if (s) begin
      exact = sa - sb;
      sum = ua - ub;
      cy = (ua < ub);
    end else begin
      exact = sa + sb;
      sum = ua + ub;
      cy = (sum > 64'hFFFF_FFFF);
    end
    e_res = sum[31:0];
    ov = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
    n = e_res[31];
    z = (e_res == 32'd0);
    lt = m_flags[3] ^ m_flags[1];
    case (c[1:0])
      2'd0: base = 1'b0;
      2'd1: base = m_flags[2];
      2'd2: base = m_flags[2] | lt;
      default: base = lt;
    endcase
    e_taken = c[2] ? !base : base;
    check(im ? "R5 result immediate" : "R4 result", result, e_res);
    check("R1 R2 R3 R4 flags", {28'd0, flags}, {28'd0, m_flags});
    check(cond_tag(c), {31'd0, taken}, {31'd0, e_taken});
    if (v && cc) m_flags = {n, z, ov, cy};
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    opnd_a = 32'hFFFF_FFFF; op_valid = 1; set_cc = 1;
    @(posedge clk); #2;
    check("R9 reset flags", {28'd0, flags}, 32'd0);
    @(negedge clk);
    op_valid = 0; set_cc = 0;
    rst_n = 1'b1;
    // R1/R7: zero result, then equal taken next cycle
    step(1, 1, 1, 0, 32'd5, 32'd5, '0, 3'b001);
    step(0, 0, 0, 0, 32'd0, 32'd0, '0, 3'b001);
    step(0, 0, 0, 0, 32'd0, 32'd0, '0, 3'b101);
    // R2 borrow and R7 less
    step(1, 1, 1, 0, 32'd3, 32'd5, '0, 3'b011);
    step(0, 0, 0, 0, 32'd0, 32'd0, '0, 3'b011);
    step(0, 0, 0, 0, 32'd0, 32'd0, '0, 3'b111);
    // R3 overflow on add and on subtract
    step(1, 0, 1, 0, 32'h7FFF_FFFF, 32'd1, '0, 3'b010);
    step(1, 1, 1, 0, 32'h8000_0000, 32'd1, '0, 3'b110);
    step(0, 0, 0, 0, 32'd0, 32'd0, '0, 3'b011);
    // R2 carry out and zero on add
    step(1, 0, 1, 0, 32'hFFFF_FFFF, 32'd1, '0, 3'b001);
    // R4: non-setting ops and invalid ops leave flags
    step(1, 1, 0, 0, 32'd1, 32'd9, '0, 3'b001);
    step(0, 1, 1, 0, 32'd1, 32'd9, '0, 3'b001);
    step(0, 0, 0, 0, 32'd0, 32'd0, '0, 3'b101);
    // R5 immediate extremes, opnd_b ignored
    step(1, 0, 1, 1, 32'd4096, 32'hDEAD_BEEF, 13'h1000, 3'b001);
    step(1, 1, 1, 1, 32'd10, 32'h1234_5678, 13'h0FFF, 3'b011);
    step(1, 0, 1, 1, 32'd0, 32'd7, 13'h1FFF, 3'b010);
    // R6 always/never with various flags
    step(0, 0, 0, 0, 32'd0, 32'd0, '0, 3'b100);
    step(0, 0, 0, 0, 32'd0, 32'd0, '0, 3'b000);
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = {ra[31], 31'h7FFF_FFFF};
      step($urandom_range(0, 3) != 0, 1'($urandom()), 1'($urandom()), 1'($urandom()),
           ra, rb, 13'($urandom()), 3'($urandom()));
    end
    summary();
  end
endmodule